// File: doc/BRIEF.md
# Shift and Rotate-Through-Carry Unit

This block is the shift stage of an integer execution pipe. It works on 64-bit registers with an operand size of 1, 2, 4 or 8 bytes. It performs logical left shifts, logical and arithmetic right shifts, plain rotates in both directions, and rotates in both directions that pass through the carry flag. The shift count comes either from a count register or from an 8-bit immediate.

Each accepted operation writes its result only into the low operand-size bytes of the old destination value. The bytes above the operand size keep their old contents. The unit also produces the new carry flag. Other flags are computed elsewhere.

The unit has one register stage. An operation presented with `inValid` in one cycle appears on `result`, `carryOut` and `outValid` after the next rising clock edge.

Top module: `shift_rot_unit`

## Requirements
- R1: The size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes; the operand width W is 8, 16, 32 or 64 bits. The count comes from the low bits of `cntReg` when `useImm` is 0, and from `cntImm` when it is 1. The count is then masked to 6 bits for size code 3 and to 5 bits for every other size.
- R2: Opcode 0 is a logical left shift. It fills the vacated low bits with zeros. The carry is the last bit shifted out of bit W-1, and it is 0 when the count exceeds W.
- R3: Opcode 1 is a logical right shift. It fills the vacated upper bits of the W-bit field with zeros. The carry is the last bit shifted out of bit 0, and it is 0 when the count exceeds W.
- R4: Opcode 2 is an arithmetic right shift. It fills the vacated upper bits with bit W-1 of the source. The carry is the last bit shifted out, and it equals the sign bit when the count is W or more.
- R5: Opcode 3 rotates left and opcode 4 rotates right, within W bits, by the count modulo W. The carry is the bit that last wrapped around: bit 0 of the result for a left rotate and bit W-1 for a right rotate.
- R6: Opcode 5 rotates left through the carry. It acts as a rotation of the (W+1)-bit value {carry, source} by the count modulo W+1. With a reduced count k > 0, the old carry lands in result bit k-1, and the new carry is the bit rotated out of the top.
- R7: Opcode 6 rotates right through the carry. It acts as a rotation of {carry, source} by the count modulo W+1. With a reduced count k > 0, the old carry lands in result bit W-k, and source bits 0 through k-2 fill the bits above it.
- R8: A masked count of zero leaves the carry unchanged. For opcodes 3 to 6 it also leaves the whole destination equal to the old destination. For opcodes 0 to 2 the result is the unshifted source, merged as in R9.
- R9: Result bits below W come from the operation. Result bits W and above equal the old destination bits.
- R10: Opcode 7 is a no-operation: the result equals the old destination and the carry equals the incoming carry.
- R11: `outValid`, `result` and `carryOut` update one cycle after an operation with `inValid` high. In a cycle without `inValid`, `outValid` drops and `result` and `carryOut` hold.
- R12: During reset, `outValid`, `result` and `carryOut` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation select (R2 to R7, R10) |
| sizeCode | input | 2 | Operand size select (R1) |
| useImm | input | 1 | 1 takes the count from cntImm |
| srcVal | input | 64 | Value to shift or rotate |
| cntReg | input | 64 | Count register operand |
| cntImm | input | 8 | Immediate count |
| carryIn | input | 1 | Current carry flag |
| oldDest | input | 64 | Old destination value for merging |
| outValid | output | 1 | Result valid |
| result | output | 64 | Merged result |
| carryOut | output | 1 | New carry flag |

## Verification
A wrong reduced count or lane select appears at the ports one cycle after the operation, as a wrong result or carry. The merge exposes any damage above the operand size, because the bench drives old-destination patterns that differ from the source. A carry that should hold but drifts, or a zero-count rotate that writes anyway, is caught at the very next output. The carry is only visible as it leaves the unit, so it is checked on every operation against a model that steps the rotation one bit at a time.

// File: rtl/shift_unit_pkg.sv
package shift_unit_pkg;
  localparam int SR_DATA_W = 64;
  localparam int SR_NSIZE  = $clog2(SR_DATA_W / 8) + 1;
  localparam int SR_SZ_W   = $clog2(SR_NSIZE);
  localparam int SR_CNT_W  = $clog2(SR_DATA_W);
  localparam int SR_IMM_W  = 8;

  typedef enum logic [2:0] {
    OP_SHL = 3'd0,
    OP_SHR = 3'd1,
    OP_SAR = 3'd2,
    OP_ROL = 3'd3,
    OP_ROR = 3'd4,
    OP_RCL = 3'd5,
    OP_RCR = 3'd6,
    OP_NOP = 3'd7
  } shOp_e;

  typedef struct packed {
    logic                load;
    shOp_e               op;
    logic [SR_SZ_W-1:0]  sizeSel;
    logic [SR_CNT_W-1:0] cnt;
    logic                keepDest;
    logic                holdCarry;
  } shStrobe_t;
endpackage

// File: rtl/shift_rot_lane.sv
module shift_rot_lane
  import shift_unit_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]        src,
  input  logic [SR_CNT_W-1:0] cnt,
  input  shOp_e               op,
  input  logic                cf,
  output logic [W-1:0]        res,
  output logic                co
);
  localparam int LG = $clog2(W);
  localparam int EW = W + 1;
  localparam int RCW = SR_CNT_W + 1;

  logic [W:0]     wideL, wideR, wideA;
  logic [W:0]     ext, rclV, rcrV;
  logic [W-1:0]   rolV, rorV;
  logic [RCW-1:0] rc;
  logic [LG-1:0]  rp;

  always_comb begin
    // shifts: one spare bit catches the last bit pushed out
    wideL = {1'b0, src} << cnt;
    wideR = {src, 1'b0} >> cnt;
    wideA = $signed({src, 1'b0}) >>> cnt;
    // plain rotate, count modulo W
    rp   = cnt[LG-1:0];
    rolV = (src << rp) | (src >> (W - 32'(rp)));
    rorV = (src >> rp) | (src << (W - 32'(rp)));
    // rotate through carry, count modulo W+1
    ext  = {cf, src};
    rc   = RCW'({1'b0, cnt} % RCW'(EW));
    rclV = (ext << rc) | (ext >> (EW - 32'(rc)));
    rcrV = (ext >> rc) | (ext << (EW - 32'(rc)));
    case (op)
      OP_SHL:  begin res = wideL[W-1:0]; co = wideL[W];   end
      OP_SHR:  begin res = wideR[W:1];   co = wideR[0];   end
      OP_SAR:  begin res = wideA[W:1];   co = wideA[0];   end
      OP_ROL:  begin res = rolV;         co = rolV[0];    end
      OP_ROR:  begin res = rorV;         co = rorV[W-1];  end
      OP_RCL:  begin res = rclV[W-1:0];  co = rclV[W];    end
      OP_RCR:  begin res = rcrV[W-1:0];  co = rcrV[W];    end
      default: begin res = src;          co = cf;         end
    endcase
  end
endmodule

// File: rtl/shift_rot_ctrl.sv
module shift_rot_ctrl
  import shift_unit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic [2:0]           opCode,
  input  logic [SR_SZ_W-1:0]   sizeCode,
  input  logic                 useImm,
  input  logic [SR_DATA_W-1:0] cntReg,
  input  logic [SR_IMM_W-1:0]  cntImm,
  output shStrobe_t            stb,
  output logic                 outValid
);
  localparam logic [SR_SZ_W-1:0] SZ_FULL = SR_SZ_W'(SR_NSIZE - 1);

  logic [SR_CNT_W-1:0] rawCnt, maskedCnt;
  logic                isRot, isNop, cntZero;
  logic                unusedCntBits;

  assign unusedCntBits = ^{cntReg[SR_DATA_W-1:SR_CNT_W], cntImm[SR_IMM_W-1:SR_CNT_W]};

  always_comb begin
    rawCnt    = useImm ? cntImm[SR_CNT_W-1:0] : cntReg[SR_CNT_W-1:0];
    maskedCnt = (sizeCode == SZ_FULL) ? rawCnt : {1'b0, rawCnt[SR_CNT_W-2:0]};
    isNop     = (opCode == OP_NOP);
    isRot     = (opCode >= OP_ROL) && !isNop;
    cntZero   = (maskedCnt == '0);

    stb.load      = inValid;
    stb.op        = shOp_e'(opCode);
    stb.sizeSel   = sizeCode;
    stb.cnt       = maskedCnt;
    stb.keepDest  = isNop || (isRot && cntZero);
    stb.holdCarry = isNop || cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end
endmodule

// File: rtl/shift_rot_dp.sv
module shift_rot_dp
  import shift_unit_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  shStrobe_t            stb,
  input  logic [SR_DATA_W-1:0] srcVal,
  input  logic                 carryIn,
  input  logic [SR_DATA_W-1:0] oldDest,
  output logic [SR_DATA_W-1:0] result,
  output logic                 carryOut
);
  logic [SR_DATA_W-1:0] laneRes  [SR_NSIZE];
  logic [SR_DATA_W-1:0] laneMask [SR_NSIZE];
  logic                 laneCo   [SR_NSIZE];

  for (genvar k = 0; k < SR_NSIZE; k++) begin : g_lane
    localparam int LW = 8 << k;
    logic [LW-1:0] lr;
    shift_rot_lane #(.W(LW)) u_lane (
      .src (srcVal[LW-1:0]),
      .cnt (stb.cnt),
      .op  (stb.op),
      .cf  (carryIn),
      .res (lr),
      .co  (laneCo[k])
    );
    assign laneRes[k]  = SR_DATA_W'(lr);
    assign laneMask[k] = SR_DATA_W'({LW{1'b1}});
  end

  logic [SR_DATA_W-1:0] selMask, merged;
  logic                 nextCarry;

  always_comb begin
    selMask   = laneMask[stb.sizeSel];
    merged    = (oldDest & ~selMask) | (laneRes[stb.sizeSel] & selMask);
    nextCarry = stb.holdCarry ? carryIn : laneCo[stb.sizeSel];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result   <= '0;
      carryOut <= 1'b0;
    end else if (stb.load) begin
      result   <= stb.keepDest ? oldDest : merged;
      carryOut <= nextCarry;
    end
  end

  // R8
  keep_dest_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.keepDest) |=> (result == $past(oldDest)));

  // R8
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.holdCarry) |=> (carryOut == $past(carryIn)));

  // R9
  upper_bytes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.load && stb.sizeSel == '0)
      |=> (result[SR_DATA_W-1:8] == $past(oldDest[SR_DATA_W-1:8])));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && $past(rstN)) |=> ($stable(result) && $stable(carryOut)));
endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import shift_unit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [2:0]  opCode,
  input  logic [1:0]  sizeCode,
  input  logic        useImm,
  input  logic [63:0] srcVal,
  input  logic [63:0] cntReg,
  input  logic [7:0]  cntImm,
  input  logic        carryIn,
  input  logic [63:0] oldDest,
  output logic        outValid,
  output logic [63:0] result,
  output logic        carryOut
);
  shStrobe_t stb;

  shift_rot_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .sizeCode (sizeCode),
    .useImm   (useImm),
    .cntReg   (cntReg),
    .cntImm   (cntImm),
    .stb      (stb),
    .outValid (outValid)
  );

  shift_rot_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcVal   (srcVal),
    .carryIn  (carryIn),
    .oldDest  (oldDest),
    .result   (result),
    .carryOut (carryOut)
  );
endmodule

// File: tb/shift_rot_unit_bench.sv
module shift_rot_unit_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [2:0]  opCode;
  logic [1:0]  sizeCode;
  logic        useImm;
  logic [63:0] srcVal, cntReg, oldDest;
  logic [7:0]  cntImm;
  logic        carryIn;
  logic        outValid;
  logic [63:0] result;
  logic        carryOut;

  always #5 clk = ~clk;

  shift_rot_unit u_shift_rot_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .sizeCode(sizeCode), .useImm(useImm), .srcVal(srcVal), .cntReg(cntReg),
    .cntImm(cntImm), .carryIn(carryIn), .oldDest(oldDest),
    .outValid(outValid), .result(result), .carryOut(carryOut)
  );

  typedef struct {
    logic [63:0] res;
    logic        co;
    string       tag;
  } expItem_t;

  expItem_t    sb[$];
  int          total = 0;
  int          bad = 0;
  bit          finished = 0;
  logic [63:0] lastRes;
  logic        lastCo;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // bit-serial reference: steps the operation one position per iteration
  function automatic logic [64:0] refModel(input int op, input int sz,
      input logic [63:0] src, input logic [63:0] creg, input logic [7:0] imm,
      input bit selImm, input logic cf, input logic [63:0] dest);
    int          w;
    int          n;
    logic [63:0] m;
    logic [63:0] v;
    logic        c;
    logic        t;
    w = 8 << sz;
    m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    n = selImm ? int'(imm) : int'(creg[7:0]);
    n = n & ((sz == 3) ? 63 : 31);
    v = src & m;
    c = cf;
    if (op == 7 || (op >= 3 && n == 0)) return {cf, dest};
    for (int i = 0; i < n; i++) begin
      case (op)
        0: begin c = v[w-1]; v = (v << 1) & m; end
        1: begin c = v[0]; v = v >> 1; end
        2: begin t = v[w-1]; c = v[0]; v = (v >> 1) | (64'(t) << (w - 1)); end
        3: begin c = v[w-1]; v = ((v << 1) | 64'(c)) & m; end
        4: begin c = v[0]; v = (v >> 1) | (64'(c) << (w - 1)); end
        5: begin t = v[w-1]; v = ((v << 1) | 64'(c)) & m; c = t; end
        default: begin t = v[0]; v = (v >> 1) | (64'(c) << (w - 1)); c = t; end
      endcase
    end
    return {c, (dest & ~m) | (v & m)};
  endfunction

  task automatic send(input int op, input int sz, input logic [63:0] src,
      input logic [63:0] creg, input logic [7:0] imm, input bit selImm,
      input logic cf, input logic [63:0] dest, input string tag);
    logic [64:0] e;
    expItem_t    it;
    @(negedge clk);
    inValid  = 1'b1;
    opCode   = 3'(op);
    sizeCode = 2'(sz);
    srcVal   = src;
    cntReg   = creg;
    cntImm   = imm;
    useImm   = selImm;
    carryIn  = cf;
    oldDest  = dest;
    e        = refModel(op, sz, src, creg, imm, selImm, cf, dest);
    it.res   = e[63:0];
    it.co    = e[64];
    it.tag   = tag;
    lastRes  = e[63:0];
    lastCo   = e[64];
    sb.push_back(it);
  endtask

  // monitor: compares every valid output against the oldest expected item
  always @(negedge clk) begin
    if (rstN === 1'b1 && outValid === 1'b1) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected valid", 64'(outValid), 64'd0);
      end else begin
        expItem_t it;
        it = sb.pop_front();
        chk(result === it.res, {it.tag, " result"}, result, it.res);
        chk(carryOut === it.co, {it.tag, " carry"}, 64'(carryOut), 64'(it.co));
      end
    end
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      summary();
      $finish;
    end
  end

  localparam logic [63:0] PAT = 64'hA5C3_1E97_6B2D_F048;
  localparam logic [63:0] DST = 64'h1122_3344_5566_7788;

  initial begin
    string tagOf[8];
    tagOf = '{"R2", "R3", "R4", "R5", "R5", "R6", "R7", "R10"};
    rstN = 1'b0; inValid = 1'b0; opCode = '0; sizeCode = '0; useImm = 1'b0;
    srcVal = '0; cntReg = '0; cntImm = '0; carryIn = 1'b0; oldDest = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(outValid === 1'b0, "R12 outValid", 64'(outValid), 64'd0);
    chk(result === 64'd0, "R12 result", result, 64'd0);
    chk(carryOut === 1'b0, "R12 carry", 64'(carryOut), 64'd0);
    rstN = 1'b1;

    // R2 left shift, including counts equal to and above the width
    send(0, 3, PAT, 64'd4, 8'd0, 0, 1'b0, DST, "R2");
    send(0, 0, PAT, 64'd9, 8'd0, 0, 1'b1, DST, "R2");
    send(0, 0, 64'h01, 64'd8, 8'd0, 0, 1'b0, DST, "R2");
    // R3 logical right
    send(1, 1, PAT, 64'd3, 8'd0, 0, 1'b0, DST, "R3");
    send(1, 2, 64'hFFFF_FFFF, 64'd31, 8'd0, 0, 1'b0, DST, "R3");
    // R4 arithmetic right
    send(2, 0, 64'h96, 64'd3, 8'd0, 0, 1'b0, DST, "R4");
    send(2, 0, 64'h80, 64'd20, 8'd0, 0, 1'b0, DST, "R4");
    send(2, 3, PAT, 64'd63, 8'd0, 0, 1'b0, DST, "R4");
    // R5 plain rotates
    send(3, 0, 64'hB1, 64'd3, 8'd0, 0, 1'b0, DST, "R5");
    send(4, 3, PAT, 64'd63, 8'd0, 0, 1'b0, DST, "R5");
    send(3, 0, 64'hB1, 64'd8, 8'd0, 0, 1'b0, DST, "R5");
    send(4, 1, 64'h8001, 64'd1, 8'd0, 0, 1'b0, DST, "R5");
    // R6 rotate left through carry
    send(5, 0, 64'h80, 64'd1, 8'd0, 0, 1'b1, DST, "R6");
    send(5, 0, 64'h5A, 64'd9, 8'd0, 0, 1'b1, DST, "R6");
    send(5, 3, PAT, 64'd40, 8'd0, 0, 1'b1, DST, "R6");
    send(5, 1, 64'h0000, 64'd17, 8'd0, 0, 1'b1, DST, "R6");
    // R7 rotate right through carry
    send(7 - 1, 1, 64'h1234, 64'd5, 8'd0, 0, 1'b1, DST, "R7");
    send(6, 0, 64'h01, 64'd17, 8'd0, 0, 1'b0, DST, "R7");
    send(6, 2, PAT, 64'd31, 8'd0, 0, 1'b1, DST, "R7");
    // R1 count source and masking
    send(0, 0, 64'h03, 64'hFFFF_0047, 8'd0, 0, 1'b0, DST, "R1");
    send(0, 3, 64'h03, 64'hFFFF_0047, 8'd0, 0, 1'b0, DST, "R1");
    send(4, 3, PAT, 64'd1, 8'hE5, 1, 1'b0, DST, "R1");
    send(4, 0, 64'h3C, 64'd1, 8'hE5, 1, 1'b0, DST, "R1");
    // R8 zero counts
    send(3, 0, PAT, 64'd32, 8'd0, 0, 1'b1, DST, "R8");
    send(6, 3, PAT, 64'd64, 8'd0, 0, 1'b1, DST, "R8");
    send(0, 2, PAT, 64'd0, 8'd0, 0, 1'b1, DST, "R8");
    // R9 merge for every size
    for (int s = 0; s < 4; s++) send(1, s, PAT, 64'd2, 8'd0, 0, 1'b0, ~PAT, "R9");
    // R10 no-op opcode
    send(7, 1, PAT, 64'd5, 8'd0, 0, 1'b1, DST, "R10");
    // mixed random stream
    for (int i = 0; i < 300; i++) begin
      int op;
      op = int'($urandom_range(0, 7));
      send(op, int'($urandom_range(0, 3)), {$urandom, $urandom},
           {$urandom, $urandom}, 8'($urandom), bit'($urandom_range(0, 1)),
           1'($urandom), {$urandom, $urandom}, tagOf[op]);
    end
    // R11 hold when idle
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    chk(outValid === 1'b0, "R11 idle valid", 64'(outValid), 64'd0);
    chk(result === lastRes, "R11 idle result", result, lastRes);
    chk(carryOut === lastCo, "R11 idle carry", 64'(carryOut), 64'(lastCo));
    repeat (2) @(negedge clk);
    chk(sb.size() == 0, "R11 pending items", 64'(sb.size()), 64'd0);
    finished = 1;
    summary();
    $finish;
  end
endmodule